// File: doc/BRIEF.md
# MSI Doorbell Interrupt Controller

This block sits behind the inbound write path of a PCIe root port and turns message-signalled interrupt writes into a bank of latched interrupt vectors with one combined interrupt line toward the CPU. An inbound write is treated as a doorbell only when its address equals a programmable target address and its low data half matches a programmable pattern under a programmable mask. The lowest data bits of an accepted write then name the vector whose pending bit is set.

Software sees a 32-bit register bus. Through it, software programs the target address and the data match rule, reads the pending and mask bits, sets, clears, masks and unmasks vectors with write-one operations, and issues an end-of-interrupt write. Once the combined line has been raised it will not rise again until that end-of-interrupt write arrives. This keeps a handler that clears and re-enables from missing or double-taking an edge.

Top module: `msi_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, STATUS reads 0, MASK_STATUS reads 0xFFFFFFFF (all masked), irq_o is 0, the controller is armed, TGT_LO reads 0xFFFFFFFC (enable bit 0 clear), TGT_HI reads 0x0000000F and DCFG reads 0xFFF86540.
- R2: Register word indices are STATUS=0, SET=1, CLR=2, MASK_STATUS=3, MASK_SET=4, MASK_CLR=5, TGT_LO=6, TGT_HI=7, DCFG=8, EOI=9. SET, CLR, MASK_SET, MASK_CLR, EOI and the unused indices 10 to 15 read 0. A write to STATUS or to MASK_STATUS changes nothing.
- R3: An inbound write is accepted only when TGT_LO bit 0 is 1 and in_addr[63:1] equals {TGT_HI, TGT_LO[31:1]}. in_addr bit 0 is not compared. A write that is not accepted leaves STATUS unchanged.
- R4: An inbound write with a matching address is accepted when (in_data[15:0] AND DCFG[31:16]) equals (DCFG[15:0] AND DCFG[31:16]). in_data[31:16] is ignored. The write then sets STATUS bit in_data[4:0] on the next clock edge.
- R5: Each 1 bit written to SET sets that STATUS bit, and each 1 bit written to CLR clears it. Bits written as 0 have no effect.
- R6: Each 1 bit written to MASK_SET sets that mask bit, and each 1 bit written to MASK_CLR clears it. MASK_STATUS reads the mask bits. STATUS reads the raw pending bits whatever the mask holds.
- R7: When an accepted inbound write and a CLR write hit the same vector in the same cycle, that STATUS bit ends up set.
- R8: When the controller is armed and some STATUS bit is pending and unmasked, irq_o goes to 1 on the next clock edge and the controller disarms at the same edge.
- R9: irq_o goes to 0 on the clock edge after no unmasked pending bit remains. After that it stays 0 until a write to EOI with bit 0 = 1 re-arms the controller. A write to EOI with bit 0 = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Inbound write present this cycle |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index, used for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Combined interrupt line to the CPU |

## Verification
The bench builds the block with its defaults: 32 vectors and a 64-bit address. The full-width vector number therefore reaches bit 31, and the target comparison spans a non-zero upper address word. With these values the bench can reject a write that differs only in the upper word. It can accept vector 31 once the data mask is widened. It also shows that vector 8 is refused under the reset mask, which covers only three vector bits. A behavioural model tracks pending, mask and arm state on every clock, so that the disarm after a raise, the drop when the last bit clears, and the re-arm through end-of-interrupt are checked cycle by cycle.

// File: rtl/msi_irq_pkg.sv
// Shared definitions for the MSI doorbell interrupt controller.
// Assumes a 16-entry word-indexed register space. The vector bank order is fixed.
package msi_irq_pkg;
    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RG_STATUS = 4'd0,
        RG_SET    = 4'd1,
        RG_CLR    = 4'd2,
        RG_MSTAT  = 4'd3,
        RG_MSET   = 4'd4,
        RG_MCLR   = 4'd5,
        RG_TGT_LO = 4'd6,
        RG_TGT_HI = 4'd7,
        RG_DCFG   = 4'd8,
        RG_EOI    = 4'd9
    } reg_idx_e;

    localparam logic [31:0] TGT_LO_RST = 32'hFFFF_FFFC;
    localparam logic [31:0] TGT_HI_RST = 32'h0000_000F;
    localparam logic [31:0] DCFG_RST   = 32'hFFF8_6540;
endpackage

// File: rtl/msi_match.sv
// Doorbell decoder: checks an inbound write against the target address and
// the masked data pattern, and outputs a one-hot vector hit.
// Assumes NUM_VEC is a power of two no larger than 32. Address bit 0 is not compared.
module msi_match #(
    parameter int NUM_VEC = 32,
    parameter int ADDR_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tgt_en,
    input  logic [ADDR_W-1:0]  tgt_addr,
    input  logic [15:0]        dmask,
    input  logic [15:0]        dpat,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [15:0]        in_data,
    output logic [NUM_VEC-1:0] hit
);
    localparam int VEC_W = $clog2(NUM_VEC);

    logic             addr_eq;
    logic             data_eq;
    logic             accept;
    logic [VEC_W-1:0] vec;

    // Compare the address (ignoring bit 0) and the masked data half.
    always_comb begin
        addr_eq = (in_addr[ADDR_W-1:1] == tgt_addr[ADDR_W-1:1]);
        data_eq = ((in_data & dmask) == (dpat & dmask));
        accept  = in_valid && tgt_en && addr_eq && data_eq;
        vec     = in_data[VEC_W-1:0];
    end

    // One decode gate per vector.
    for (genvar i = 0; i < NUM_VEC; i++) begin : g_dec
        assign hit[i] = accept && (vec == VEC_W'(i));
    end

    // R4
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));
    // R3
    hit_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |-> (tgt_en && in_valid));
endmodule

// File: rtl/msi_vec_bank.sv
// Pending and mask registers for the vectors.
// Set sources (inbound hit, software SET) take priority over CLR on the same bit.
// Assumes at most one software write per cycle.
module msi_vec_bank #(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] msi_hit,
    input  logic [NUM_VEC-1:0] set_bits,
    input  logic [NUM_VEC-1:0] clr_bits,
    input  logic [NUM_VEC-1:0] mset_bits,
    input  logic [NUM_VEC-1:0] mclr_bits,
    output logic [NUM_VEC-1:0] status,
    output logic [NUM_VEC-1:0] mask,
    output logic               pending_any
);
    // Update the pending and mask bits; on reset clear pending and mask every vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '1;
        end else begin
            status <= (status & ~clr_bits) | set_bits | msi_hit;
            mask   <= (mask | mset_bits) & ~mclr_bits;
        end
    end

    // Flag whether any vector is pending and unmasked.
    always_comb pending_any = |(status & ~mask);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_hit != '0) |=> ((status & $past(msi_hit)) == $past(msi_hit)));
    // R5
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_bits != '0) |=> ((status & $past(clr_bits & ~set_bits & ~msi_hit)) == '0));
    // R6
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mset_bits != '0) |=> ((mask & $past(mset_bits)) == $past(mset_bits)));
endmodule

// File: rtl/msi_irq_gate.sv
// Combined interrupt line with an arm flag.
// The line rises when the controller is armed and something is pending; the rise
// disarms it. The line falls once nothing is pending. Only EOI re-arms.
module msi_irq_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic pending_any,
    input  logic eoi,
    output logic irq_o
);
    logic armed;
    logic irq_q;
    logic fire;

    // Decide whether the line rises this cycle.
    always_comb fire = armed && pending_any;

    // Hold the arm flag and the output level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
            irq_q <= 1'b0;
        end else begin
            if (eoi)       armed <= 1'b1;
            else if (fire) armed <= 1'b0;
            if (fire)              irq_q <= 1'b1;
            else if (!pending_any) irq_q <= 1'b0;
        end
    end

    assign irq_o = irq_q;

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(armed));
    // R9
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pending_any |=> !irq_q);
    // R9
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !irq_q) |=> !irq_q);
endmodule

// File: rtl/msi_irq_ctrl.sv
// MSI doorbell interrupt controller top: register file for the target address and
// data rule, write-one strobes into the vector bank, read mux and interrupt gate.
// Assumes a single-cycle register write and combinational read data.
module msi_irq_ctrl
    import msi_irq_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int ADDR_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [31:0]       in_data,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_o
);
    localparam int HI_W = ADDR_W - 32;

    logic [31:0]      tgt_lo;
    logic [HI_W-1:0]  tgt_hi;
    logic [31:0]      dcfg;
    logic [NUM_VEC-1:0] msi_hit, set_bits, clr_bits, mset_bits, mclr_bits;
    logic [NUM_VEC-1:0] status, mask;
    logic             pending_any;
    logic             eoi;
    logic             unused_hi_data;

    assign unused_hi_data = ^in_data[31:16];

    // Turn a register write into per-vector write-one strobes.
    always_comb begin
        set_bits  = (reg_we && reg_addr == RG_SET)  ? reg_wdata[NUM_VEC-1:0] : '0;
        clr_bits  = (reg_we && reg_addr == RG_CLR)  ? reg_wdata[NUM_VEC-1:0] : '0;
        mset_bits = (reg_we && reg_addr == RG_MSET) ? reg_wdata[NUM_VEC-1:0] : '0;
        mclr_bits = (reg_we && reg_addr == RG_MCLR) ? reg_wdata[NUM_VEC-1:0] : '0;
        eoi       = reg_we && (reg_addr == RG_EOI) && reg_wdata[0];
    end

    // Hold the target address and the data match configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_lo <= TGT_LO_RST;
            tgt_hi <= TGT_HI_RST[HI_W-1:0];
            dcfg   <= DCFG_RST;
        end else if (reg_we) begin
            case (reg_addr)
                RG_TGT_LO: tgt_lo <= reg_wdata;
                RG_TGT_HI: tgt_hi <= reg_wdata[HI_W-1:0];
                RG_DCFG:   dcfg   <= reg_wdata;
                default:   ;
            endcase
        end
    end

    // Select the read data; write-only and unused words read as zero.
    always_comb begin
        case (reg_addr)
            RG_STATUS: reg_rdata = 32'(status);
            RG_MSTAT:  reg_rdata = 32'(mask);
            RG_TGT_LO: reg_rdata = tgt_lo;
            RG_TGT_HI: reg_rdata = 32'(tgt_hi);
            RG_DCFG:   reg_rdata = dcfg;
            default:   reg_rdata = '0;
        endcase
    end

    msi_match #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .tgt_en   (tgt_lo[0]),
        .tgt_addr ({tgt_hi, tgt_lo[31:1], 1'b0}),
        .dmask    (dcfg[31:16]),
        .dpat     (dcfg[15:0]),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .in_data  (in_data[15:0]),
        .hit      (msi_hit)
    );

    msi_vec_bank #(.NUM_VEC(NUM_VEC)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .msi_hit     (msi_hit),
        .set_bits    (set_bits),
        .clr_bits    (clr_bits),
        .mset_bits   (mset_bits),
        .mclr_bits   (mclr_bits),
        .status      (status),
        .mask        (mask),
        .pending_any (pending_any)
    );

    msi_irq_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .pending_any (pending_any),
        .eoi         (eoi),
        .irq_o       (irq_o)
    );

    // R3
    tgt_lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == RG_TGT_LO) |=> (tgt_lo == $past(reg_wdata)));
endmodule

// File: tb/msi_irq_ctrl_test.sv
`timescale 1ns/100ps
module msi_irq_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    localparam logic [63:0] TGT = 64'h0000_000F_FFFF_FFFC;

    always #2.5 clk = ~clk;

    msi_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_data(in_data), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // Behavioural reference state.
    logic [31:0] m_stat, m_mask, m_tlo, m_thi, m_dcfg;
    bit          m_armed, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat = 0; m_mask = 32'hFFFF_FFFF; m_armed = 1; m_irq = 0;
            m_tlo = 32'hFFFF_FFFC; m_thi = 32'hF; m_dcfg = 32'hFFF8_6540;
        end else begin
            bit pend, fire;
            logic [31:0] hitv, setv, clrv;
            hitv = 0; setv = 0; clrv = 0;
            pend = (m_stat & ~m_mask) != 0;
            fire = m_armed && pend;
            if (in_valid && m_tlo[0] && in_addr[63:1] == {m_thi, m_tlo[31:1]} &&
                ((in_data[15:0] & m_dcfg[31:16]) == (m_dcfg[15:0] & m_dcfg[31:16])))
                hitv = 32'd1 << in_data[4:0];
            if (reg_we) begin
                case (reg_addr)
                    1: setv = reg_wdata;
                    2: clrv = reg_wdata;
                    4: m_mask = m_mask | reg_wdata;
                    5: m_mask = m_mask & ~reg_wdata;
                    6: m_tlo = reg_wdata;
                    7: m_thi = reg_wdata;
                    8: m_dcfg = reg_wdata;
                    default: ;
                endcase
            end
            m_stat = (m_stat & ~clrv) | setv | hitv;
            if (fire) m_irq = 1; else if (!pend) m_irq = 0;
            if (reg_we && reg_addr == 9 && reg_wdata[0]) m_armed = 1;
            else if (fire) m_armed = 0;
        end
    end

    function automatic logic [31:0] exp_rd(input logic [3:0] a);
        case (a)
            0: return m_stat;
            3: return m_mask;
            6: return m_tlo;
            7: return m_thi;
            8: return m_dcfg;
            default: return 0;
        endcase
    endfunction

    // Compare the outputs with the model one step after every edge.
    always @(posedge clk) begin
        #1;
        if (!done) begin
            n_cmp++;
            if (irq_o !== m_irq) begin
                n_bad++;
                $display("FAIL %s R8 R9 irq_o: actual %0b expected %0b at %0t", tag, irq_o, m_irq, $time);
            end
            n_cmp++;
            if (reg_rdata !== exp_rd(reg_addr)) begin
                n_bad++;
                $display("FAIL %s reg[%0d]: actual %h expected %h at %0t", tag, reg_addr,
                         reg_rdata, exp_rd(reg_addr), $time);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input logic [3:0] a);
        reg_addr = a;
        @(negedge clk);
    endtask

    task automatic msi(input logic [63:0] a, input logic [31:0] d);
        in_valid = 1; in_addr = a; in_data = d;
        @(negedge clk);
        in_valid = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #20000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1;
        tag = "R1";
        for (int a = 0; a < 10; a++) rd(4'(a));

        tag = "R3";
        msi(TGT, 32'h6541);                       // enable bit clear: ignored
        rd(0);
        wr(5, 32'hFFFF_FFFF);                     // unmask all
        wr(6, 32'hFFFF_FFFD);                     // enable
        msi(64'h0000_001F_FFFF_FFFC, 32'h6542);   // upper word differs
        rd(0);
        msi(TGT | 64'h1, 32'h6541);               // bit 0 not compared: vec 1
        rd(0); idle(2);
        rd(6);

        tag = "R4";
        msi(TGT, 32'h6547);                       // vec 7
        msi(TGT, 32'h6548);                       // masked-out pattern bit: rejected
        msi(TGT, 32'h7540);                       // pattern mismatch
        rd(0);
        wr(8, 32'hFFE0_6540);
        msi(TGT, 32'hABCD_655F);                  // vec 31, upper data ignored
        rd(0); rd(8);

        tag = "R9";
        wr(2, 32'hFFFF_FFFF);                     // nothing pending
        idle(2);
        msi(TGT, 32'h6543);                       // pending but disarmed
        idle(3);
        wr(9, 32'h0000_0000);                     // no effect
        idle(3);
        wr(9, 32'h0000_0001);                     // re-arm
        idle(3);

        tag = "R5";
        wr(2, 32'hFFFF_FFFF);
        wr(1, 32'h0001_0001);
        rd(0);
        wr(2, 32'h0000_0001);
        rd(0);
        tag = "R2";
        wr(0, 32'hFFFF_FFFF);                     // STATUS write ignored
        rd(0);
        wr(3, 32'h0000_0000);                     // MASK_STATUS write ignored
        rd(3);
        for (int a = 9; a < 16; a++) rd(4'(a));
        rd(1); rd(2); rd(4); rd(5);

        tag = "R6";
        wr(4, 32'hFFFF_FFFF);
        rd(0); rd(3); idle(2);
        wr(9, 1);
        idle(2);
        wr(5, 32'h0001_0000);                     // unmask vec 16: irq rises
        rd(3); idle(3);

        tag = "R7";
        wr(2, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF);
        wr(9, 1);
        in_valid = 1; in_addr = TGT; in_data = 32'h6545;
        reg_we = 1; reg_addr = 2; reg_wdata = 32'h0000_0020;
        @(negedge clk);
        in_valid = 0; reg_we = 0;
        rd(0); idle(3);

        tag = "R8";
        wr(2, 32'hFFFF_FFFF);
        wr(9, 1);
        msi(TGT, 32'h6540);
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule